// File: doc/BRIEF.md
# Halting Programmable Clock Divider

This block derives a tile's local clock from a fast source clock by integer division, with the ratio set through an 8-bit field. A tile that has run out of work raises a halt request. A tile has no work when its input queue is empty or its output queue is full. The divider keeps clocking for a fixed drain of nine output cycles so that the tile pipeline can empty, and then it holds the clock low. When the request falls, the clock starts again within a few source cycles. No output period is lost waiting for a divider wrap.

The halt request is brought into the source domain through a synchronizer. The output is produced glitch-free from a register for every ratio except the pass-through ratio. For that ratio the source clock is gated by an enable that only changes while the source clock is low. A new ratio is latched only when an output period begins, so a period that is already running keeps its length.

Top module: `halting_clk_div`

## Requirements
- R1: While rst_n is low, clk_out is low. After rst_n rises, the first clk_out rising edge comes at the first clk_src rising edge that follows the release (ratios 2 to 128).
- R2: For a ratio N from 2 to 128, clk_out has a period of N source cycles. Each period begins with a high phase of floor(N/2) source cycles.
- R3: The ratio field is read as follows: 0 and 1 select pass-through, 2 to 128 select that ratio, and any value above 128 selects 128. In pass-through, clk_out follows clk_src: a period of one source cycle and a high phase equal to the source high phase.
- R4: A new div_ratio value written during an output period does not shorten or lengthen that period. It sets the length of the next period.
- R5: halt_req may rise just after a clk_out rising edge while the ratio is 3 or more. In that case exactly 9 further clk_out rising edges occur, and then the clock stops.
- R6: Once stopped, clk_out stays low and shows no rising edge for as long as halt_req stays high.
- R7: halt_req is synchronized by two source-clock flops. When halt_req falls while the clock is stopped, the next clk_out rising edge comes on the third clk_src rising edge after the fall for ratios 2 to 128, and on the fourth in pass-through.
- R8: If halt_req falls before the drain ends, the drain is cancelled and clk_out keeps its period with no gap. A later halt then gets a full 9-edge drain again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock, treated as ideal |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_ratio | input | 8 | Division ratio field (0 and 1 pass-through, above 128 saturates) |
| halt_req | input | 1 | Tile has no work (asynchronous to clk_src) |
| clk_out | output | 1 | Divided, gated tile clock |

## Verification
Every result is due at a fixed source-clock count after its stimulus:
- The first edge after reset comes on the next source edge.
- A ratio written during an output period applies one period later.
- The halt count is nine output edges, starting at the first boundary at least three source cycles after the request.
- The restart edge comes three source cycles after the request falls, or four in pass-through.

The bench changes inputs 1 ns after a source edge. It timestamps clk_out edges and compares the measured intervals in nanoseconds with values that its own functions derive from the ratio field. Edge counts are read only after waiting windows that are long enough to cover the full drain or period. This keeps each count exact rather than bounded.

// File: rtl/hcd_pkg.sv
`timescale 1ns/1ps
package hcd_pkg;

  // Coarse view of the halt sequencer, exposed for checking.
  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_DRAIN = 2'd1,
    PH_SPENT = 2'd2
  } phase_t;

  // Effective divide ratio for a raw field value.
  function automatic int ratio_of(input int field, input int max_ratio);
    if (field <= 1) return 1;
    if (field > max_ratio) return max_ratio;
    return field;
  endfunction

  // Number of source cycles the output stays high in one period.
  function automatic int high_len(input int ratio);
    return ratio / 2;
  endfunction

endpackage

// File: rtl/hcd_sync.sv
`timescale 1ns/1ps
module hcd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hcd_period_ctr.sv
`timescale 1ns/1ps
module hcd_period_ctr
  import hcd_pkg::*;
#(
  parameter int MAX_RATIO = 128,
  parameter int FIELD_W   = 8,
  parameter int LW        = $clog2(MAX_RATIO + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] ratio_field,
  input  logic               start_i,     // begin a new period at this boundary
  output logic               boundary_o,  // this cycle may begin a period
  output logic               active_o,    // a period is in progress
  output logic [LW-1:0]      len_o,       // latched ratio of current period
  output logic               hi_o         // registered divided clock
);
  logic [LW-1:0] cnt_q, len_q, next_len, half_cur;
  logic          active_q, hi_q;
  logic          last_cycle;

  assign next_len   = LW'(ratio_of(int'(ratio_field), MAX_RATIO));
  assign half_cur   = LW'(high_len(int'(len_q)));
  assign last_cycle = (cnt_q == len_q - LW'(1));
  assign boundary_o = !active_q || last_cycle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      len_q    <= LW'(1);
      active_q <= 1'b0;
      hi_q     <= 1'b0;
    end else if (boundary_o) begin
      cnt_q <= '0;
      if (start_i) begin
        active_q <= 1'b1;
        len_q    <= next_len;
        hi_q     <= (next_len > LW'(1));
      end else begin
        active_q <= 1'b0;
        hi_q     <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_q + LW'(1);
      hi_q  <= ((cnt_q + LW'(1)) < half_cur);
    end
  end

  assign active_o = active_q;
  assign len_o    = len_q;
  assign hi_o     = hi_q;

  // R4: the latched ratio holds for the whole period
  a_r4_len_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !boundary_o) |=> $stable(len_q));

  // R2: the divided clock rises only as a period begins
  a_r2_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_q) |-> (active_q && cnt_q == '0));

  // R2: the phase counter stays inside the latched period
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < len_q));
endmodule

// File: rtl/hcd_halt_ctrl.sv
`timescale 1ns/1ps
module hcd_halt_ctrl
  import hcd_pkg::*;
#(
  parameter int DRAIN_CYCLES = 9,
  parameter int DW           = $clog2(DRAIN_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt_s,    // synchronized halt request
  input  logic          boundary,  // counter may begin a period
  output logic          start_o,   // begin a period at this boundary
  output logic [DW-1:0] drain_o,
  output phase_t        phase_o
);
  logic [DW-1:0] drain_q;
  logic          spent;

  assign spent   = (drain_q == DW'(DRAIN_CYCLES));
  assign start_o = boundary && !(halt_s && spent);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_q <= '0;
    end else if (boundary) begin
      if (!halt_s)     drain_q <= '0;
      else if (!spent) drain_q <= drain_q + DW'(1);
    end
  end

  always_comb begin
    if (halt_s && spent)    phase_o = PH_SPENT;
    else if (drain_q != '0) phase_o = PH_DRAIN;
    else                    phase_o = PH_RUN;
  end

  assign drain_o = drain_q;

  // R5: the drain count never passes its limit
  a_r5_drain_cap: assert property (@(posedge clk) disable iff (!rst_n)
    drain_q <= DW'(DRAIN_CYCLES));
endmodule

// File: rtl/hcd_clk_gate.sv
`timescale 1ns/1ps
module hcd_clk_gate (
  input  logic clk_src,
  input  logic rst_n,
  input  logic pass_mode,  // current period ratio is one
  input  logic pulse_arm,  // a one-cycle period was started
  input  logic div_hi,     // registered divided clock
  output logic clk_o
);
  logic en_q;

  // Enable changes only while clk_src is low, so no runt pulse.
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= pulse_arm;
  end

  assign clk_o = pass_mode ? (clk_src & en_q) : div_hi;
endmodule

// File: rtl/halting_clk_div.sv
`timescale 1ns/1ps
module halting_clk_div
  import hcd_pkg::*;
#(
  parameter int MAX_RATIO    = 128,
  parameter int FIELD_W      = 8,
  parameter int DRAIN_CYCLES = 9,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] div_ratio,
  input  logic               halt_req,
  output logic               clk_out
);
  localparam int LW = $clog2(MAX_RATIO + 1);
  localparam int DW = $clog2(DRAIN_CYCLES + 1);

  logic          halt_s, boundary, start, active, div_hi;
  logic          pass_mode, pulse_arm;
  logic [LW-1:0] len;
  logic [DW-1:0] drain;
  phase_t        phase;

  hcd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_src), .rst_n(rst_n), .d(halt_req), .q(halt_s)
  );

  hcd_period_ctr #(.MAX_RATIO(MAX_RATIO), .FIELD_W(FIELD_W), .LW(LW)) u_ctr (
    .clk(clk_src), .rst_n(rst_n), .ratio_field(div_ratio), .start_i(start),
    .boundary_o(boundary), .active_o(active), .len_o(len), .hi_o(div_hi)
  );

  hcd_halt_ctrl #(.DRAIN_CYCLES(DRAIN_CYCLES), .DW(DW)) u_halt (
    .clk(clk_src), .rst_n(rst_n), .halt_s(halt_s), .boundary(boundary),
    .start_o(start), .drain_o(drain), .phase_o(phase)
  );

  assign pass_mode = (len == LW'(1));
  assign pulse_arm = active && pass_mode;

  hcd_clk_gate u_gate (
    .clk_src(clk_src), .rst_n(rst_n), .pass_mode(pass_mode),
    .pulse_arm(pulse_arm), .div_hi(div_hi), .clk_o(clk_out)
  );

  // R6: with the drain spent and no period running, the divided clock is low
  a_r6_spent_quiet: assert property (@(posedge clk_src) disable iff (!rst_n)
    (phase == PH_SPENT && !active) |-> !div_hi);

  // R7: an idle divider without a halt begins a period on the next edge
  a_r7_resume_next: assert property (@(posedge clk_src) disable iff (!rst_n)
    (!active && !halt_s) |=> active);

  // R5: the drain count moves only at period boundaries
  a_r5_drain_on_boundary: assert property (@(posedge clk_src) disable iff (!rst_n)
    !boundary |=> $stable(drain));
endmodule

// File: tb/halting_clk_div_bench.sv
`timescale 1ns/1ps
module halting_clk_div_bench;
  logic       clk_src = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_req = 1'b0;
  logic [7:0] div_ratio = 8'd4;
  logic       clk_out;
  int total = 0;
  int bad = 0;
  int rises = 0;

  always #2 clk_src = ~clk_src;   // 250 MHz

  halting_clk_div u_halting_clk_div (
    .clk_src(clk_src), .rst_n(rst_n), .div_ratio(div_ratio),
    .halt_req(halt_req), .clk_out(clk_out)
  );

  always @(posedge clk_out) rises++;

  function automatic int exp_ratio(input int f);
    if (f < 2) return 1;
    return (f > 128) ? 128 : f;
  endfunction

  function automatic int exp_high_ns(input int f);
    int n = exp_ratio(f);
    return (n == 1) ? 2 : (n / 2) * 4;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_ratio(input int f);
    @(posedge clk_src); #1 div_ratio = 8'(f);
    @(posedge clk_out); @(posedge clk_out);
  endtask

  task automatic measure(output int per_ns, output int high_ns);
    time t0, t1, t2;
    @(posedge clk_out); t0 = $time;
    @(negedge clk_out); t1 = $time;
    @(posedge clk_out); t2 = $time;
    per_ns = int'(t2 - t0);
    high_ns = int'(t1 - t0);
  endtask

  task automatic ratio_case(input int f);
    int p, h;
    set_ratio(f);
    measure(p, h);
    if (exp_ratio(f) == 1 || f > 128) begin
      check($sformatf("R3 period f=%0d", f), p, exp_ratio(f) * 4);
      check($sformatf("R3 high f=%0d", f), h, exp_high_ns(f));
    end else begin
      check($sformatf("R2 period f=%0d", f), p, exp_ratio(f) * 4);
      check($sformatf("R2 high f=%0d", f), h, exp_high_ns(f));
    end
  endtask

  task automatic drain_case(input int f);
    int snap;
    time td;
    set_ratio(f);
    @(posedge clk_out); #1 halt_req = 1'b1;
    snap = rises;
    repeat (11 * f + 20) @(posedge clk_src);
    #1 check($sformatf("R5 drain edges f=%0d", f), rises - snap, 9);
    snap = rises;
    repeat (60) @(posedge clk_src);
    #1 check($sformatf("R6 quiet edges f=%0d", f), rises - snap, 0);
    check("R6 held low", clk_out, 0);
    @(posedge clk_src); #1 halt_req = 1'b0; td = $time;
    @(posedge clk_out);
    check($sformatf("R7 restart ns f=%0d", f), $time - td, 11);
  endtask

  initial begin
    time tr, t0, t1, t2;
    int snap;
    void'($urandom(32'd5150));

    // R1: reset state
    repeat (3) @(posedge clk_src);
    #1 check("R1 low in reset", clk_out, 0);
    repeat (3) @(negedge clk_src);
    #1 check("R1 low in reset (low phase)", clk_out, 0);
    @(posedge clk_src); #1 rst_n = 1'b1; tr = $time;
    @(posedge clk_out);
    check("R1 first edge ns", $time - tr, 3);

    // R2/R3 directed ratios
    ratio_case(2); ratio_case(3); ratio_case(4); ratio_case(7); ratio_case(128);
    ratio_case(0); ratio_case(1); ratio_case(200);

    // R2/R3 random ratios
    for (int i = 0; i < 10; i++) ratio_case(int'($urandom_range(255, 0)));

    // R4: change mid-period
    set_ratio(6);
    @(posedge clk_out); t0 = $time; #1 div_ratio = 8'd10;
    @(posedge clk_out); t1 = $time;
    @(posedge clk_out); t2 = $time;
    check("R4 current period kept", t1 - t0, 24);
    check("R4 next period new", t2 - t1, 40);

    // R5/R6/R7 drain, hold and restart
    drain_case(3); drain_case(5); drain_case(16);
    for (int i = 0; i < 3; i++) drain_case(int'($urandom_range(40, 3)));

    // R7 pass-through restart
    set_ratio(1);
    #1 halt_req = 1'b1;
    repeat (40) @(posedge clk_src);
    snap = rises;
    repeat (20) @(posedge clk_src);
    #1 check("R6 pass-through quiet", rises - snap, 0);
    @(posedge clk_src); #1 halt_req = 1'b0; tr = $time;
    @(posedge clk_out);
    check("R7 pass-through restart ns", $time - tr, 15);

    // R8: cancel during drain, then a full drain again
    set_ratio(4);
    @(posedge clk_out); #1 halt_req = 1'b1;
    repeat (3) @(posedge clk_out);
    #1 halt_req = 1'b0;
    snap = rises;
    repeat (200) @(posedge clk_src);
    #1 check("R8 no gap after cancel", rises - snap, 50);
    @(posedge clk_out); #1 halt_req = 1'b1;
    snap = rises;
    repeat (80) @(posedge clk_src);
    #1 check("R8 full drain after cancel", rises - snap, 9);
    halt_req = 1'b0;
    repeat (10) @(posedge clk_src);

    // R1: reset while running
    set_ratio(8);
    @(posedge clk_out); #1 rst_n = 1'b0;
    #1 check("R1 reset forces low", clk_out, 0);
    repeat (5) @(posedge clk_src);
    #1 check("R1 low during reset", clk_out, 0);
    @(posedge clk_src); #1 rst_n = 1'b1; tr = $time;
    @(posedge clk_out);
    check("R1 edge after re-reset ns", $time - tr, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    total++;
    bad++;
    $display("FAIL watchdog R1..R8 actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule